// File: doc/BRIEF.md
# Packet Buffer Allocation Unit

This unit owns a pool of numbered packet buffers that the transmit and receive paths of a network controller share. Each buffer has a six-bit packet number and holds a whole number of 256-byte pages taken from a fixed page budget. The unit keeps track of which numbers and how many pages are free. It also runs three queues of packet numbers: frames waiting to transmit, frames whose transmission has finished, and frames that have been received. The buffer contents, the MAC and the host data path are outside this block.

The host sends 3-bit commands through an 8-bit command port. It can request a transmit buffer, release a buffer, queue a buffer for transmission, drop the head receive entry with or without freeing it, flush the transmit queues or reset the whole unit. The MAC side has its own inputs. It stores received frames, which takes a buffer with no host involvement, and it signals the end of each transmission. The host reads back the allocation result word, a busy flag and a combined queue-status word.

Top module: `pba_top`

## Requirements
- R1: After reset, busy is 0, alloc_result is 16'h80C0, fifo_ports is 16'h8080, tx_empty is 1, and alloc_done and rx_dropped are 0.
- R2: Commands are taken from cmd_data on a clock edge where cmd_wr is 1 and busy is 0. The code is in bits 7:5 and the argument in the low bits. pnr is sampled at that same edge. busy is 1 from that edge until the edge where the command executes, which is the next one unless R11 applies. A write while busy is 1 is ignored.
- R3: Code 1 (allocate) with argument k asks for k+1 pages. If a packet number and enough pages are free, it takes the lowest free number. alloc_result then becomes {8'h00, 2'b00, number} and alloc_done pulses for one cycle.
- R4: An allocation that cannot be served sets alloc_result to 16'h80C0 (bit 15 set means failure, and bits 7:6 set mark the number invalid). The request stays pending. On the first cycle after enough resources become free, it is granted as in R3, with an alloc_done pulse.
- R5: Code 5 frees the buffer numbered by pnr and returns its pages. If that number is at the head of the transmit-done queue, it is also removed from the queue. Releasing a number that is already free changes nothing.
- R6: Code 6 appends pnr to the transmit queue. tx_head and tx_empty show that queue's head in first-in order.
- R7: tx_done removes the transmit-queue head. If tx_ok and auto_release are both 1, the buffer is freed. Otherwise the number is appended to the transmit-done queue. fifo_ports bit 7 flags that queue as empty and bits 5:0 hold its head.
- R8: rx_store takes the lowest free number with rx_pages+1 pages and appends it to the receive queue. fifo_ports bit 15 flags that queue as empty and bits 13:8 hold its head. If no buffer is available, rx_dropped pulses for one cycle.
- R9: Code 3 removes the receive head and keeps its buffer allocated. Code 4 removes the receive head and frees its buffer.
- R10: Code 7 empties the transmit and transmit-done queues and leaves buffers allocated. Code 2 frees every buffer, empties all queues, cancels a pending allocation and restores alloc_result to 16'h80C0.
- R11: An allocate command waits while rx_store is 1. A release command (code 4 or 5) waits while an automatic release is happening. busy stays 1 while a command waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command word: code in 7:5, argument in low bits |
| pnr | input | 6 | Packet number used by the release and enqueue commands |
| auto_release | input | 1 | Free successfully transmitted buffers directly |
| rx_store | input | 1 | MAC stores a received frame |
| rx_pages | input | 3 | Pages minus one for the received frame |
| tx_done | input | 1 | MAC finished the transmit-queue head |
| tx_ok | input | 1 | That transmission succeeded |
| busy | output | 1 | Command pending |
| alloc_result | output | 16 | Allocation result word |
| alloc_done | output | 1 | One-cycle pulse on each granted host allocation |
| fifo_ports | output | 16 | Receive and transmit-done queue status |
| tx_head | output | 6 | Transmit-queue head number |
| tx_empty | output | 1 | Transmit queue empty |
| rx_dropped | output | 1 | One-cycle pulse when a received frame found no buffer |

## Verification
The bench aims at deferred allocation. A design that never retries would leave alloc_result at the failure value after the release, and one that retries too eagerly would grant before the pages return. It releases the same number twice and then fills the pool exactly, so a unit that credits pages twice grants an allocation that should fail. It checks that code 3 keeps its buffer and code 4 frees it, that a flush keeps buffers allocated, and that auto-release skips the done queue, by watching which number the next allocation gets. It also writes a command while busy and collides an allocation with rx_store. A wrong design would then run a command twice or hand one number out twice.

// File: rtl/pba_pkg.sv
package pba_pkg;
    localparam int PNUM_W = 6;
    typedef logic [PNUM_W-1:0] pnum_t;

    typedef enum logic [2:0] {
        CMD_NOP      = 3'd0,
        CMD_ALLOC    = 3'd1,
        CMD_RESET    = 3'd2,
        CMD_RX_DROP  = 3'd3,
        CMD_RX_FREE  = 3'd4,
        CMD_RELEASE  = 3'd5,
        CMD_ENQUEUE  = 3'd6,
        CMD_TX_FLUSH = 3'd7
    } cmd_t;

    typedef struct packed {
        cmd_t       code;
        logic [4:0] arg;
        pnum_t      num;
    } pend_t;

    localparam logic [15:0] RESULT_NONE = 16'h80C0;

    function automatic logic [15:0] result_ok(input pnum_t n);
        return {8'h00, 2'b00, n};
    endfunction
endpackage

// File: rtl/pba_fifo.sv
module pba_fifo
    import pba_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  push,
    input  pnum_t push_num,
    input  logic  pop,
    output pnum_t head,
    output logic  empty
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    pnum_t          mem [DEPTH];
    logic [IW-1:0]  wr_q, rd_q;
    logic [CW-1:0]  cnt_q;
    logic           push_ok, pop_ok;

    function automatic logic [IW-1:0] step(input logic [IW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    assign push_ok = push && (int'(cnt_q) != DEPTH);
    assign pop_ok  = pop && (cnt_q != '0);
    assign empty   = (cnt_q == '0);
    assign head    = empty ? '0 : mem[rd_q];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) begin
                mem[wr_q] <= push_num;
                wr_q      <= step(wr_q);
            end
            if (pop_ok)
                rd_q <= step(rd_q);
            if (push_ok && !pop_ok)
                cnt_q <= cnt_q + 1'b1;
            else if (pop_ok && !push_ok)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
        (push_ok && !pop_ok && !clear) |=> (cnt_q == $past(cnt_q) + 1'b1))
        else $error("queue count did not grow on push");
endmodule

// File: rtl/pba_pool.sv
module pba_pool
    import pba_pkg::*;
#(
    parameter int NUM_PKTS    = 8,
    parameter int TOTAL_PAGES = 16,
    parameter int PG_W        = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            alloc_en,
    input  logic [PG_W-1:0] alloc_pages,
    input  logic            rel_en,
    input  pnum_t           rel_num,
    output logic            fit,
    output pnum_t           grant
);
    localparam int IW = (NUM_PKTS > 1) ? $clog2(NUM_PKTS) : 1;

    logic [NUM_PKTS-1:0] used_q;
    logic [PG_W-1:0]     pages_q [NUM_PKTS];
    logic [PG_W-1:0]     free_q;
    logic                any_free, take, rel_ok;
    logic [IW-1:0]       gi, ri;

    always_comb begin
        any_free = 1'b0;
        grant    = '0;
        for (int i = NUM_PKTS - 1; i >= 0; i--) begin
            if (!used_q[i]) begin
                any_free = 1'b1;
                grant    = pnum_t'(i);
            end
        end
    end

    assign gi     = grant[IW-1:0];
    assign ri     = rel_num[IW-1:0];
    assign fit    = any_free && (free_q >= alloc_pages);
    assign take   = alloc_en && fit;
    assign rel_ok = rel_en && (int'(rel_num) < NUM_PKTS) && used_q[ri];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            used_q <= '0;
            free_q <= PG_W'(TOTAL_PAGES);
            for (int i = 0; i < NUM_PKTS; i++)
                pages_q[i] <= '0;
        end else begin
            if (rel_ok) begin
                used_q[ri]  <= 1'b0;
                pages_q[ri] <= '0;
            end
            if (take) begin
                used_q[gi]  <= 1'b1;
                pages_q[gi] <= alloc_pages;
            end
            free_q <= free_q - (take ? alloc_pages : '0)
                             + (rel_ok ? pages_q[ri] : '0);
        end
    end

    int held_sum;
    always_comb begin
        held_sum = 0;
        for (int i = 0; i < NUM_PKTS; i++)
            held_sum += int'(pages_q[i]);
    end

    always_ff @(posedge clk) begin
        if (!rst)
            p_page_sum_r5: assert (held_sum + int'(free_q) == TOTAL_PAGES)
                else $error("page accounting broken");
    end

    p_grant_free_r3: assert property (@(posedge clk) disable iff (rst)
        (take && !clear) |=> used_q[$past(gi)])
        else $error("granted buffer not marked used");
endmodule

// File: rtl/pba_top.sv
module pba_top
    import pba_pkg::*;
#(
    parameter int NUM_PKTS    = 8,
    parameter int TOTAL_PAGES = 16,
    parameter int SIZE_W      = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic [7:0]        cmd_data,
    input  logic [5:0]        pnr,
    input  logic              auto_release,
    input  logic              rx_store,
    input  logic [SIZE_W-1:0] rx_pages,
    input  logic              tx_done,
    input  logic              tx_ok,
    output logic              busy,
    output logic [15:0]       alloc_result,
    output logic              alloc_done,
    output logic [15:0]       fifo_ports,
    output logic [5:0]        tx_head,
    output logic              tx_empty,
    output logic              rx_dropped
);
    localparam int PG_W = $clog2(TOTAL_PAGES + 1);

    pend_t            pend_q;
    logic             pend_v_q;
    logic             wait_q;
    logic [PG_W-1:0]  wait_pages_q;
    logic [15:0]      result_q;
    logic             done_q, drop_q;

    logic             exec, stall, auto_free, retry, do_reset, do_flush;
    logic             pool_fit, pool_alloc, pool_rel;
    logic [PG_W-1:0]  pool_pages, cmd_pages;
    pnum_t            pool_grant, pool_rel_num;
    pnum_t            txq_head, txd_head, rxq_head;
    logic             txq_empty, txd_empty, rxq_empty;

    function automatic logic is_cmd(input logic ex, input pend_t p, input cmd_t c);
        return ex && (p.code == c);
    endfunction

    assign busy      = pend_v_q;
    assign cmd_pages = PG_W'(pend_q.arg[SIZE_W-1:0]) + 1'b1;
    assign auto_free = tx_done && !txq_empty && tx_ok && auto_release;
    assign stall     = ((pend_q.code == CMD_ALLOC) && rx_store) ||
                       (((pend_q.code == CMD_RX_FREE) || (pend_q.code == CMD_RELEASE)) && auto_free);
    assign exec      = pend_v_q && !stall;
    assign do_reset  = is_cmd(exec, pend_q, CMD_RESET);
    assign do_flush  = is_cmd(exec, pend_q, CMD_TX_FLUSH) || do_reset;
    assign retry     = wait_q && !rx_store && !is_cmd(exec, pend_q, CMD_ALLOC) && !do_reset;

    assign pool_alloc = rx_store || is_cmd(exec, pend_q, CMD_ALLOC) || retry;
    assign pool_pages = rx_store ? (PG_W'(rx_pages) + 1'b1) :
                        (is_cmd(exec, pend_q, CMD_ALLOC) ? cmd_pages : wait_pages_q);
    assign pool_rel   = auto_free || is_cmd(exec, pend_q, CMD_RELEASE) ||
                        (is_cmd(exec, pend_q, CMD_RX_FREE) && !rxq_empty);
    assign pool_rel_num = auto_free ? txq_head :
                          (is_cmd(exec, pend_q, CMD_RX_FREE) ? rxq_head : pend_q.num);

    pba_pool #(.NUM_PKTS(NUM_PKTS), .TOTAL_PAGES(TOTAL_PAGES), .PG_W(PG_W)) u_pool (
        .clk(clk), .rst(rst), .clear(do_reset),
        .alloc_en(pool_alloc), .alloc_pages(pool_pages),
        .rel_en(pool_rel), .rel_num(pool_rel_num),
        .fit(pool_fit), .grant(pool_grant)
    );

    pba_fifo #(.DEPTH(NUM_PKTS)) u_txq (
        .clk(clk), .rst(rst), .clear(do_flush),
        .push(is_cmd(exec, pend_q, CMD_ENQUEUE)), .push_num(pend_q.num),
        .pop(tx_done), .head(txq_head), .empty(txq_empty)
    );

    pba_fifo #(.DEPTH(NUM_PKTS)) u_txdone (
        .clk(clk), .rst(rst), .clear(do_flush),
        .push(tx_done && !txq_empty && !(tx_ok && auto_release)), .push_num(txq_head),
        .pop(is_cmd(exec, pend_q, CMD_RELEASE) && !txd_empty && (txd_head == pend_q.num)),
        .head(txd_head), .empty(txd_empty)
    );

    pba_fifo #(.DEPTH(NUM_PKTS)) u_rxq (
        .clk(clk), .rst(rst), .clear(do_reset),
        .push(rx_store && pool_fit), .push_num(pool_grant),
        .pop(is_cmd(exec, pend_q, CMD_RX_DROP) || is_cmd(exec, pend_q, CMD_RX_FREE)),
        .head(rxq_head), .empty(rxq_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v_q <= 1'b0;
            pend_q   <= '0;
        end else begin
            if (exec)
                pend_v_q <= 1'b0;
            if (cmd_wr && !pend_v_q) begin
                pend_v_q    <= 1'b1;
                pend_q.code <= cmd_t'(cmd_data[7:5]);
                pend_q.arg  <= cmd_data[4:0];
                pend_q.num  <= pnr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || do_reset) begin
            result_q     <= RESULT_NONE;
            wait_q       <= 1'b0;
            wait_pages_q <= '0;
            done_q       <= 1'b0;
            drop_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            drop_q <= rx_store && !pool_fit;
            if (is_cmd(exec, pend_q, CMD_ALLOC)) begin
                if (pool_fit) begin
                    result_q <= result_ok(pool_grant);
                    done_q   <= 1'b1;
                    wait_q   <= 1'b0;
                end else begin
                    result_q     <= RESULT_NONE;
                    wait_q       <= 1'b1;
                    wait_pages_q <= cmd_pages;
                end
            end else if (retry && pool_fit) begin
                result_q <= result_ok(pool_grant);
                done_q   <= 1'b1;
                wait_q   <= 1'b0;
            end
        end
    end

    assign alloc_result = result_q;
    assign alloc_done   = done_q;
    assign rx_dropped   = drop_q;
    assign tx_head      = txq_head;
    assign tx_empty     = txq_empty;
    assign fifo_ports   = {rxq_empty, 1'b0, rxq_head, txd_empty, 1'b0, txd_head};

    p_busy_on_write_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !busy) |=> busy)
        else $error("accepted command did not raise busy");

    p_stall_holds_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && (pend_q.code == CMD_ALLOC) && rx_store) |=> busy)
        else $error("allocation ran alongside a receive store");

    p_done_means_ok_r4: assert property (@(posedge clk) disable iff (rst)
        alloc_done |-> (alloc_result[15:6] == '0))
        else $error("completion pulse with a failed result");
endmodule

// File: tb/pba_top_test.sv
module pba_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_wr = 1'b0;
    logic [7:0]  cmd_data = '0;
    logic [5:0]  pnr = '0;
    logic        auto_release = 1'b0;
    logic        rx_store = 1'b0;
    logic [2:0]  rx_pages = '0;
    logic        tx_done = 1'b0;
    logic        tx_ok = 1'b0;
    logic        busy, alloc_done, tx_empty, rx_dropped;
    logic [15:0] alloc_result, fifo_ports;
    logic [5:0]  tx_head;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    pba_top uut (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_data(cmd_data), .pnr(pnr),
        .auto_release(auto_release), .rx_store(rx_store), .rx_pages(rx_pages),
        .tx_done(tx_done), .tx_ok(tx_ok), .busy(busy), .alloc_result(alloc_result),
        .alloc_done(alloc_done), .fifo_ports(fifo_ports), .tx_head(tx_head),
        .tx_empty(tx_empty), .rx_dropped(rx_dropped)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // write one command, return at the falling edge after it has executed
    task automatic cmd(input logic [2:0] code, input logic [4:0] arg, input logic [5:0] num);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_data = {code, arg}; pnr = num;
        @(negedge clk);
        cmd_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic rx_frame(input logic [2:0] pg);
        @(negedge clk);
        rx_store = 1'b1; rx_pages = pg;
        @(negedge clk);
        rx_store = 1'b0;
    endtask

    task automatic tx_finish(input logic ok, input logic autor);
        @(negedge clk);
        tx_done = 1'b1; tx_ok = ok; auto_release = autor;
        @(negedge clk);
        tx_done = 1'b0; auto_release = 1'b0;
    endtask

    task automatic t_reset_state;
        chk("R1 busy", 16'(busy), 16'h0);
        chk("R1 result", alloc_result, 16'h80C0);
        chk("R1 fifo_ports", fifo_ports, 16'h8080);
        chk("R1 tx_empty", 16'(tx_empty), 16'h1);
        chk("R1 pulses", {14'h0, alloc_done, rx_dropped}, 16'h0);
    endtask

    task automatic t_alloc_and_defer;
        @(negedge clk);
        cmd_wr = 1'b1; cmd_data = {3'd1, 5'd1};
        @(negedge clk);
        cmd_wr = 1'b0;
        chk("R2 busy while pending", 16'(busy), 16'h1);
        @(negedge clk);
        chk("R2 busy clears", 16'(busy), 16'h0);
        chk("R3 first grant", alloc_result, 16'h0000);
        chk("R3 done pulse", 16'(alloc_done), 16'h1);
        cmd(3'd1, 5'd2, 6'd0);
        chk("R3 second grant", alloc_result, 16'h0001);
        cmd(3'd1, 5'd7, 6'd0);
        chk("R3 eight pages", alloc_result, 16'h0002);
        cmd(3'd1, 5'd3, 6'd0);
        chk("R4 failure word", alloc_result, 16'h80C0);
        chk("R4 no pulse on fail", 16'(alloc_done), 16'h0);
        cmd(3'd5, 5'd0, 6'd0);
        chk("R4 still failed at release", alloc_result, 16'h80C0);
        @(negedge clk);
        chk("R4 deferred grant", alloc_result, 16'h0000);
        chk("R4 deferred pulse", 16'(alloc_done), 16'h1);
    endtask

    task automatic t_double_release;
        cmd(3'd2, 5'd0, 6'd0);
        chk("R10 reset result", alloc_result, 16'h80C0);
        cmd(3'd1, 5'd7, 6'd0);
        cmd(3'd1, 5'd7, 6'd0);
        chk("R3 pool full grant", alloc_result, 16'h0001);
        cmd(3'd5, 5'd0, 6'd1);
        cmd(3'd5, 5'd0, 6'd1);
        cmd(3'd1, 5'd7, 6'd0);
        chk("R5 freed regranted", alloc_result, 16'h0001);
        cmd(3'd1, 5'd0, 6'd0);
        @(negedge clk);
        chk("R5 double release ignored", alloc_result, 16'h80C0);
        cmd(3'd2, 5'd0, 6'd0);
        @(negedge clk);
        chk("R10 pending cancelled", {alloc_result[15:1], alloc_done}, {15'h4060, 1'b0});
    endtask

    task automatic t_transmit;
        cmd(3'd2, 5'd0, 6'd0);
        cmd(3'd1, 5'd0, 6'd0);
        cmd(3'd1, 5'd0, 6'd0);
        cmd(3'd1, 5'd0, 6'd0);
        cmd(3'd6, 5'd0, 6'd2);
        cmd(3'd6, 5'd0, 6'd0);
        chk("R6 tx head", {9'h0, tx_empty, tx_head}, 16'h0002);
        tx_finish(1'b1, 1'b0);
        chk("R7 done queue", fifo_ports, 16'h8002);
        chk("R7 tx advance", 16'(tx_head), 16'h0000);
        tx_finish(1'b1, 1'b1);
        chk("R7 auto skips done queue", fifo_ports, 16'h8002);
        chk("R7 tx now empty", 16'(tx_empty), 16'h1);
        cmd(3'd1, 5'd0, 6'd0);
        chk("R7 auto freed buffer", alloc_result, 16'h0000);
        cmd(3'd5, 5'd0, 6'd2);
        chk("R5 release pops done head", fifo_ports, 16'h8080);
        cmd(3'd1, 5'd0, 6'd0);
        chk("R5 released reused", alloc_result, 16'h0002);
    endtask

    task automatic t_receive;
        cmd(3'd2, 5'd0, 6'd0);
        rx_frame(3'd1);
        chk("R8 rx queued", fifo_ports, 16'h0080);
        rx_frame(3'd0);
        chk("R8 rx order", fifo_ports, 16'h0080);
        cmd(3'd3, 5'd0, 6'd0);
        chk("R9 drop advances", fifo_ports, 16'h0180);
        cmd(3'd1, 5'd0, 6'd0);
        chk("R9 drop keeps buffer", alloc_result, 16'h0002);
        cmd(3'd4, 5'd0, 6'd0);
        chk("R9 free empties", fifo_ports, 16'h8080);
        cmd(3'd1, 5'd0, 6'd0);
        chk("R9 free returns buffer", alloc_result, 16'h0001);
        cmd(3'd2, 5'd0, 6'd0);
        cmd(3'd1, 5'd7, 6'd0);
        cmd(3'd1, 5'd7, 6'd0);
        rx_frame(3'd0);
        chk("R8 dropped pulse", 16'(rx_dropped), 16'h1);
        chk("R8 nothing queued", fifo_ports, 16'h8080);
    endtask

    task automatic t_flush;
        cmd(3'd2, 5'd0, 6'd0);
        cmd(3'd1, 5'd0, 6'd0);
        cmd(3'd1, 5'd0, 6'd0);
        cmd(3'd6, 5'd0, 6'd0);
        cmd(3'd6, 5'd0, 6'd1);
        tx_finish(1'b0, 1'b0);
        chk("R7 failed goes to done", fifo_ports, 16'h8000);
        cmd(3'd7, 5'd0, 6'd0);
        chk("R10 flush queues", {fifo_ports[15:1], tx_empty}, {15'h4040, 1'b1});
        cmd(3'd1, 5'd0, 6'd0);
        chk("R10 flush keeps buffers", alloc_result, 16'h0002);
    endtask

    task automatic t_busy_and_stall;
        cmd(3'd2, 5'd0, 6'd0);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_data = {3'd1, 5'd0};
        @(negedge clk);
        cmd_data = {3'd1, 5'd0};
        @(negedge clk);
        cmd_wr = 1'b0;
        cmd(3'd1, 5'd0, 6'd0);
        chk("R2 write while busy ignored", alloc_result, 16'h0001);
        cmd(3'd2, 5'd0, 6'd0);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_data = {3'd1, 5'd0};
        @(negedge clk);
        cmd_wr = 1'b0; rx_store = 1'b1; rx_pages = 3'd0;
        @(negedge clk);
        rx_store = 1'b0;
        chk("R11 alloc waits on rx", 16'(busy), 16'h1);
        @(negedge clk);
        chk("R11 alloc after rx", {busy, alloc_result[14:0]}, 16'h0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_alloc_and_defer();
        t_double_release();
        t_transmit();
        t_receive();
        t_flush();
        t_busy_and_stall();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule